// File: doc/BRIEF.md
# SPI Master with Held Chip Select

This block is a bus-programmed SPI master that moves one 8-bit character at a time, most significant bit first, while capturing the character that the slave returns. Software sets the clock divider, the clock polarity and the sampling phase, and two delays that frame the chip-select window. It then starts each character with one word that carries the transmit byte, the number of the chip-select line to drive and a flag that keeps that line low after the character ends.

A single holding register sits in front of the shifter. Software may place the next character there while the current one is still shifting. If the running character carries the keep flag, the queued character follows with no pause in the clock and no release of chip select. When a character is sent with the flag clear, the line returns high after the trailing delay. The received byte is placed in a one-entry buffer that reports empty and overrun status.

Top module: `spi_cs_hold_master`

## Requirements
- R1: After reset, and after any edge at which the global run bit (address 0, bit 0) reads 0, every `cs_n` line is high, `sclk` rests at the polarity level, the holding register and the receive buffer are empty, and the status word reads 32'h8000_0000. Clearing the run bit in the middle of a character abandons that character and stops the clock.
- R2: A write to address 4 takes the transmit byte from bits 7:0, the chip-select number from bits 23:16 and the keep flag from bit 28. The byte appears on `mosi` most significant bit first. The received byte is reported in bits 7:0 of the status word at address 5.
- R3: Format register (address 2): when bit 16 is 1, `miso` is sampled on the leading clock edge and `mosi` changes on the trailing edge. When bit 16 is 0, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge. Bit 17 sets the idle level of `sclk`.
- R4: Format bits 15:8 hold a divider p. One `sclk` period lasts p+1 module clocks, and p=0 is treated as p=1. The half before the leading edge lasts floor((p+1)/2) clocks and the rest follows the leading edge.
- R5: Delay register (address 3): when chip select falls from released, the first `sclk` edge comes exactly D1 + floor((p+1)/2) clocks later, where D1 is bits 31:24. Chip select rises exactly D2 clocks after the last `sclk` edge, where D2 is bits 23:16.
- R6: After a character written with the keep flag set, chip select stays low until a character with the flag clear has finished and its trailing delay has elapsed. The next character skips the setup delay.
- R7: A character that is already queued when a kept character ends starts at once. Every half-period across the boundary keeps its normal length.
- R8: The holding register is one deep and status bit 29 is 1 while it is full. A data write while it is full is ignored.
- R9: While the shift-enable bit (address 1, bit 24) is 0, a queued character waits: no clock edges, no chip select, and bit 29 stays 1.
- R10: Status bit 31 is 1 while no received byte is unread. A read of address 5 with `bus_rd` sets bit 31 back to 1 and clears the overrun bit 30. A character that completes while the previous byte is unread overwrites it and sets bit 30.
- R11: Only `cs_n[n]` goes low for chip-select number n. A number at or above NCS drives no line low, although the character is still shifted. At most one line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only at address 5) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Single characters are sent in two corners, with the phase bit set and polarity low, and with the phase bit clear and polarity high. A data pattern that differs bit by bit in each direction exposes a wrong sampling edge or a reversed shift order. A slow, odd divider with non-zero setup and trailing delays checks the edge-to-edge distances exactly, so an off-by-one in any counter shows up. Pairs of characters with the keep flag are used to tell a held frame from a re-asserted one and to find any gap in the clock. Further cases cover a write while the holding register is full, an out-of-range select number, a cleared shift enable and a cleared run bit in the middle of a character, each against its own effect at the pins or in the status word.

// File: rtl/spi_cs_hold_master.sv
module spi_cs_hold_master #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [2:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam logic [2:0] A_RUN = 3'd0, A_CTRL = 3'd1, A_FMT = 3'd2,
                         A_DLY = 3'd3, A_DATA = 3'd4, A_STAT = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_BIT, S_TAIL} st_t;

  logic       run_q, go_q, pha_q, pol_q;
  logic [7:0] pre_q, dly_on_q, dly_off_q;

  st_t        st;
  logic [8:0] cnt;
  logic       half, sact, mosi_q, cs_on, cur_keep;
  logic [2:0] bitn;
  logic [7:0] txsh, rxsh, cur_cs, rxbuf;
  logic       rx_full, ovr;
  logic       hold_full, hold_keep;
  logic [7:0] hold_byte, hold_cs;

  logic [8:0] per, lead_n, trail_n;
  logic       wr_data, rd_stat, last, start, chain, take;
  logic [7:0] rx_byte;

  assign per     = (pre_q == 8'd0) ? 9'd2 : {1'b0, pre_q} + 9'd1;
  assign lead_n  = {1'b0, per[8:1]};
  assign trail_n = per - lead_n;

  assign wr_data = bus_wr && bus_addr == A_DATA && run_q && !hold_full;
  assign rd_stat = bus_rd && bus_addr == A_STAT;
  assign last    = st == S_BIT && cnt == 9'd0 && half && bitn == 3'd7;
  assign start   = st == S_IDLE && go_q && hold_full;
  assign chain   = last && cur_keep && go_q && hold_full;
  assign take    = start || chain;
  assign rx_byte = pha_q ? rxsh : {rxsh[6:0], miso};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; go_q <= 1'b0; pha_q <= 1'b0; pol_q <= 1'b0;
      pre_q <= 8'd0; dly_on_q <= 8'd0; dly_off_q <= 8'd0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_RUN:  run_q <= bus_wdata[0];
        A_CTRL: go_q  <= bus_wdata[24];
        A_FMT:  begin pre_q <= bus_wdata[15:8]; pha_q <= bus_wdata[16]; pol_q <= bus_wdata[17]; end
        A_DLY:  begin dly_on_q <= bus_wdata[31:24]; dly_off_q <= bus_wdata[23:16]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q) begin
      st <= S_IDLE; cnt <= 9'd0; half <= 1'b0; sact <= 1'b0; mosi_q <= 1'b0;
      bitn <= 3'd0; txsh <= 8'd0; rxsh <= 8'd0; cs_on <= 1'b0; cur_cs <= 8'd0;
      cur_keep <= 1'b0; rxbuf <= 8'd0; rx_full <= 1'b0; ovr <= 1'b0;
      hold_full <= 1'b0; hold_keep <= 1'b0; hold_byte <= 8'd0; hold_cs <= 8'd0;
    end else begin
      if (wr_data) begin
        hold_full <= 1'b1;
        hold_byte <= bus_wdata[7:0];
        hold_cs   <= bus_wdata[23:16];
        hold_keep <= bus_wdata[28];
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (rd_stat) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
      end
      case (st)
        S_SETUP: if (cnt == 9'd1) begin st <= S_BIT; cnt <= lead_n - 9'd1; end
                 else cnt <= cnt - 9'd1;
        S_BIT: begin
          if (cnt != 9'd0) begin
            cnt <= cnt - 9'd1;
          end else if (!half) begin
            sact <= 1'b1; half <= 1'b1; cnt <= trail_n - 9'd1;
            if (pha_q) rxsh <= {rxsh[6:0], miso};
            else begin mosi_q <= txsh[7]; txsh <= {txsh[6:0], 1'b0}; end
          end else begin
            sact <= 1'b0; half <= 1'b0; cnt <= lead_n - 9'd1; bitn <= bitn + 3'd1;
            if (pha_q) begin mosi_q <= txsh[6]; txsh <= {txsh[6:0], 1'b0}; end
            else rxsh <= {rxsh[6:0], miso};
            if (bitn == 3'd7) begin
              rxbuf   <= rx_byte;
              rx_full <= 1'b1;
              if (rx_full && !rd_stat) ovr <= 1'b1;
              if (cur_keep) st <= S_IDLE;
              else if (dly_off_q == 8'd0) begin cs_on <= 1'b0; st <= S_IDLE; end
              else begin st <= S_TAIL; cnt <= {1'b0, dly_off_q}; end
            end
          end
        end
        S_TAIL: if (cnt == 9'd1) begin cs_on <= 1'b0; st <= S_IDLE; end
                else cnt <= cnt - 9'd1;
        default: ;
      endcase
      if (take) begin
        txsh <= hold_byte; rxsh <= 8'd0; bitn <= 3'd0; half <= 1'b0;
        cur_cs <= hold_cs; cur_keep <= hold_keep; cs_on <= 1'b1;
        if (pha_q) mosi_q <= hold_byte[7];
        if (cs_on || dly_on_q == 8'd0) begin st <= S_BIT; cnt <= lead_n - 9'd1; end
        else begin st <= S_SETUP; cnt <= {1'b0, dly_on_q}; end
      end
    end
  end

  assign sclk = pol_q ^ sact;
  assign mosi = mosi_q;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(cs_on && cur_cs == 8'(i));
  end

  always_comb begin
    case (bus_addr)
      A_RUN:   bus_rdata = {31'b0, run_q};
      A_CTRL:  bus_rdata = {7'b0, go_q, 24'b0};
      A_FMT:   bus_rdata = {14'b0, pol_q, pha_q, pre_q, 8'd8};
      A_DLY:   bus_rdata = {dly_on_q, dly_off_q, 16'b0};
      A_STAT:  bus_rdata = {~rx_full, ovr, hold_full, 21'b0, rxbuf};
      default: bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/spi_cs_hold_master_chk.sv
module spi_cs_hold_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [2:0]     bus_addr,
  input logic           sclk,
  input logic [NCS-1:0] cs_n,
  input logic           run_q,
  input logic           pol_q,
  input logic           in_char,
  input logic           last,
  input logic           rx_full,
  input logic           hold_full,
  input logic [7:0]     hold_byte
);
  // R11
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R1
  halted_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cs_n == {NCS{1'b1}}));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_char |-> (sclk == pol_q));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && hold_full && bus_wr && bus_addr == 3'd4) |=> $stable(hold_byte));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5 && !last) |=> !rx_full);
endmodule

bind spi_cs_hold_master spi_cs_hold_master_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .sclk(sclk), .cs_n(cs_n), .run_q(run_q), .pol_q(pol_q),
  .in_char(st == S_BIT), .last(last), .rx_full(rx_full),
  .hold_full(hold_full), .hold_byte(hold_byte)
);

// File: tb/spi_cs_hold_master_bench.sv
module spi_cs_hold_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd5;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic sclk, mosi, miso = 1'b0;
  logic [NCS-1:0] cs_n;

  spi_cs_hold_master #(.NCS(NCS)) u_spi_cs_hold_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  int cyc = 0, edges = 0, cs_falls = 0, cs_rises = 0, max_gap = 0;
  int t_cs_fall = 0, t_cs_rise = 0, t_last_edge = 0;
  int et[4];
  logic [NCS-1:0] lowmask = '0;
  logic prev_sclk = 1'b0, prev_low = 1'b0;
  bit s_pha = 1'b1, s_pol = 1'b0;
  logic [7:0] s_tx[4], s_rx[4], s_rxsh = 8'd0;
  int s_idx = 0, s_bit = 0, s_nrx = 0;

  always @(negedge clk) begin
    logic anylow;
    cyc++;
    anylow = ~&cs_n;
    if (anylow && !prev_low) begin cs_falls++; t_cs_fall = cyc; end
    if (!anylow && prev_low) begin cs_rises++; t_cs_rise = cyc; end
    lowmask = lowmask | ~cs_n;
    if (sclk != prev_sclk) begin
      if (edges < 4) et[edges] = cyc;
      if (edges > 0 && cyc - t_last_edge > max_gap) max_gap = cyc - t_last_edge;
      edges++;
      t_last_edge = cyc;
      if (sclk != s_pol) begin
        if (s_pha) s_rxsh = {s_rxsh[6:0], mosi};
        else miso = s_tx[s_idx & 3][7 - s_bit];
      end else begin
        if (!s_pha) s_rxsh = {s_rxsh[6:0], mosi};
        s_bit++;
        if (s_bit == 8) begin
          s_rx[s_nrx & 3] = s_rxsh; s_nrx++; s_bit = 0; s_idx++;
        end
        if (s_pha) miso = s_tx[s_idx & 3][7 - s_bit];
      end
    end
    prev_sclk = sclk;
    prev_low = anylow;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = 3'd5;
  endtask

  task automatic br(output logic [31:0] v);
    @(negedge clk); #1;
    bus_rd = 1'b1; bus_addr = 3'd5; #1;
    v = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic peek(output logic [31:0] v);
    @(negedge clk); #2;
    v = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_edges(input int n);
    for (int k = 0; k < 4000 && edges < n; k++) @(negedge clk);
  endtask

  task automatic wait_not_full();
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin
      peek(v);
      if (!v[29]) break;
    end
  endtask

  task automatic cfg(input logic [7:0] p, input bit pha, input bit pol, input logic [7:0] d1, input logic [7:0] d2);
    logic [31:0] v;
    bw(3'd2, {14'b0, pol, pha, p, 8'd8});
    bw(3'd3, {d1, d2, 16'b0});
    br(v);
    s_pha = pha; s_pol = pol;
  endtask

  task automatic prep(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk); #1;
    s_tx[0] = b0; s_tx[1] = b1; s_tx[2] = 8'h00; s_tx[3] = 8'h00;
    s_idx = 0; s_bit = 0; s_nrx = 0; s_rxsh = 8'd0;
    s_rx[0] = 8'h00; s_rx[1] = 8'h00;
    if (s_pha) miso = b0[7];
    edges = 0; cs_falls = 0; cs_rises = 0; max_gap = 0; lowmask = '0;
    prev_sclk = sclk; prev_low = ~&cs_n;
    t_cs_fall = 0; t_cs_rise = 0; t_last_edge = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] cs, input bit keep);
    bw(3'd4, {3'b0, keep, 4'b0, cs, 8'b0, b});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(v);
    chk(v == 32'h8000_0000, "R1 status after reset", v, 32'h8000_0000);
    chk(cs_n == 4'hF, "R1 cs_n after reset", 32'(cs_n), 32'hF);
    chk(sclk == 1'b0, "R1 sclk after reset", 32'(sclk), 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    cfg(8'd1, 1'b1, 1'b0, 8'd0, 8'd0);
    prep(8'h3C, 8'h00);
    send(8'hA5, 8'd1, 1'b0);
    wait_edges(16); wait_n(10);
    chk(s_rx[0] == 8'hA5, "R2 byte seen by slave", 32'(s_rx[0]), 32'hA5);
    peek(v);
    chk(v == 32'h0000_003C, "R2 R10 status after char", v, 32'h3C);
    chk(lowmask == 4'b0010, "R11 only cs1 driven", 32'(lowmask), 32'h2);
    chk(cs_rises == 1 && cs_n == 4'hF, "R6 released after clear flag", 32'(cs_rises), 32'd1);
    chk(edges == 16, "R2 edge count", 32'(edges), 32'd16);
  endtask

  task automatic t_mode_b();
    logic [31:0] v;
    cfg(8'd3, 1'b0, 1'b1, 8'd1, 8'd1);
    wait_n(2);
    chk(sclk == 1'b1, "R3 idle level high", 32'(sclk), 32'd1);
    prep(8'h5A, 8'h00);
    send(8'h96, 8'd2, 1'b0);
    wait_edges(16); wait_n(10);
    chk(s_rx[0] == 8'h96, "R3 phase0 mosi", 32'(s_rx[0]), 32'h96);
    peek(v);
    chk(v[7:0] == 8'h5A, "R3 phase0 miso sample", 32'(v[7:0]), 32'h5A);
    chk(lowmask == 4'b0100, "R11 only cs2 driven", 32'(lowmask), 32'h4);
  endtask

  task automatic t_timing();
    cfg(8'd4, 1'b1, 1'b0, 8'd3, 8'd2);
    prep(8'h81, 8'h00);
    send(8'h42, 8'd0, 1'b0);
    wait_edges(16); wait_n(12);
    chk(et[0] - t_cs_fall == 5, "R5 setup to first edge", 32'(et[0] - t_cs_fall), 32'd5);
    chk(t_cs_rise - t_last_edge == 2, "R5 last edge to release", 32'(t_cs_rise - t_last_edge), 32'd2);
    chk(et[1] - et[0] == 3, "R4 trailing half", 32'(et[1] - et[0]), 32'd3);
    chk(et[2] - et[0] == 5, "R4 full period", 32'(et[2] - et[0]), 32'd5);
    chk(s_rx[0] == 8'h42, "R2 byte at slow divider", 32'(s_rx[0]), 32'h42);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    cfg(8'd0, 1'b1, 1'b0, 8'd2, 8'd0);
    prep(8'h11, 8'h22);
    send(8'hC3, 8'd0, 1'b1);
    wait_not_full();
    send(8'h7E, 8'd0, 1'b0);
    wait_edges(32); wait_n(10);
    chk(cs_falls == 1 && cs_rises == 1, "R6 single frame", 32'(cs_falls), 32'd1);
    chk(edges == 32, "R7 edges in frame", 32'(edges), 32'd32);
    chk(max_gap == 1, "R7 no clock gap", 32'(max_gap), 32'd1);
    chk(s_rx[0] == 8'hC3 && s_rx[1] == 8'h7E, "R2 both bytes", {16'b0, s_rx[0], s_rx[1]}, 32'hC37E);
    peek(v);
    chk(v[31:29] == 3'b010 && v[7:0] == 8'h22, "R10 overrun and overwrite", v, 32'h4000_0022);
    br(v);
    peek(v);
    chk(v[31:29] == 3'b100, "R10 read clears", 32'(v[31:29]), 32'h4);
  endtask

  task automatic t_hold_stay();
    logic [31:0] v;
    cfg(8'd0, 1'b1, 1'b0, 8'd2, 8'd0);
    prep(8'h00, 8'h00);
    send(8'h44, 8'd3, 1'b1);
    wait_edges(16); wait_n(60);
    chk(cs_n == 4'b0111, "R6 held after char", 32'(cs_n), 32'h7);
    send(8'h55, 8'd3, 1'b0);
    wait_edges(32); wait_n(10);
    chk(cs_falls == 1 && cs_n == 4'hF, "R6 no reassert then release", 32'(cs_falls), 32'd1);
    br(v);
  endtask

  task automatic t_txfull();
    logic [31:0] v;
    cfg(8'd2, 1'b1, 1'b0, 8'd0, 8'd0);
    prep(8'h00, 8'h00);
    send(8'hA1, 8'd0, 1'b0);
    wait_not_full();
    send(8'hA2, 8'd0, 1'b0);
    peek(v);
    chk(v[29] == 1'b1, "R8 full flag", 32'(v[29]), 32'd1);
    send(8'hA3, 8'd0, 1'b0);
    wait_edges(32); wait_n(60);
    chk(edges == 32 && s_nrx == 2, "R8 write while full dropped", 32'(edges), 32'd32);
    chk(s_rx[1] == 8'hA2, "R8 kept queued byte", 32'(s_rx[1]), 32'hA2);
    br(v);
  endtask

  task automatic t_oor();
    logic [31:0] v;
    cfg(8'd1, 1'b1, 1'b0, 8'd0, 8'd0);
    prep(8'h6D, 8'h00);
    send(8'h99, 8'd7, 1'b0);
    wait_edges(16); wait_n(10);
    chk(lowmask == 4'b0000, "R11 out of range selects none", 32'(lowmask), 32'h0);
    peek(v);
    chk(edges == 16 && v[7:0] == 8'h6D, "R11 char still shifted", v, 32'h6D);
    br(v);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    cfg(8'd1, 1'b1, 1'b0, 8'd0, 8'd0);
    bw(3'd1, 32'h0);
    prep(8'h00, 8'h00);
    send(8'h33, 8'd0, 1'b0);
    wait_n(40);
    peek(v);
    chk(edges == 0 && cs_falls == 0, "R9 gated no activity", 32'(edges), 32'd0);
    chk(v[29] == 1'b1, "R9 char still queued", 32'(v[29]), 32'd1);
    bw(3'd1, 32'h0100_0000);
    wait_edges(16); wait_n(10);
    chk(s_rx[0] == 8'h33, "R9 sent after enable", 32'(s_rx[0]), 32'h33);
    br(v);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    int n;
    cfg(8'd7, 1'b1, 1'b0, 8'd0, 8'd0);
    prep(8'h00, 8'h00);
    send(8'hF0, 8'd0, 1'b1);
    wait_edges(4);
    bw(3'd0, 32'h0);
    wait_n(3);
    peek(v);
    chk(cs_n == 4'hF && sclk == 1'b0, "R1 halt releases pins", 32'(cs_n), 32'hF);
    chk(v == 32'h8000_0000, "R1 halt clears status", v, 32'h8000_0000);
    n = edges;
    wait_n(30);
    chk(edges == n, "R1 clock stopped", 32'(edges), 32'(n));
    bw(3'd0, 32'h1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    bw(3'd0, 32'h1);
    bw(3'd1, 32'h0100_0000);
    t_basic();
    t_mode_b();
    t_timing();
    t_hold();
    t_hold_stay();
    t_txfull();
    t_oor();
    t_gate();
    t_halt();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule